// File: doc/BRIEF.md
# Single-Precision Compare to Condition Code

This block orders two packed single-precision floating-point words, a left operand and a right operand. It returns a four-bit condition code in the negative/zero/carry/overflow layout that a processor's flag logic uses directly, plus a flag that reports an invalid operation. It works on the raw 32-bit patterns. It never splits out or realigns fields: ordered operands are ranked with a sign-aware integer compare, and NaNs are detected from the exponent and fraction bits.

Two controls select the flavour of compare. The first makes any NaN raise invalid, instead of only signalling NaNs. The second replaces the right operand with positive zero, so a value can be tested against zero without routing a constant through the datapath. By default the result is registered, which gives a one-cycle latency. A valid strobe travels alongside the result.

Top module: `fcmp_nzcv`

## Requirements
- R1: When the operands are ordered and equal, the flags (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) read 4'b0110. Two words are equal when their bit patterns match, or when both are zeros of any sign, so +0 equals -0.
- R2: When the left operand is less than the right, the flags read 4'b1000.
- R3: When the left operand is greater than the right, the flags read 4'b0010.
- R4: A word is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is a NaN, the flags read 4'b0011 (unordered).
- R5: In quiet mode (sig_mode = 0), invalid is raised only when a NaN operand has bit 22 clear (a signalling NaN). A NaN with bit 22 set produces unordered flags without invalid.
- R6: In signalling mode (sig_mode = 1), invalid is raised whenever either operand is a NaN.
- R7: Ordered operands, infinities included, never raise invalid. Infinities of equal sign compare equal.
- R8: When zero_mode = 1, the right operand is taken as +0 (all bits zero), and opd_m has no effect on any output. This holds in both quiet and signalling mode.
- R9: When the signs differ and the operands are not both zero, the negative one is smaller. When the signs match, the words are ranked as unsigned integers, and the sense is inverted when both are negative.
- R10: With REG_OUT = 1, out_valid is in_valid delayed by exactly one clock, and flags and invalid belong to that accepted pair. Reset clears out_valid, flags and invalid to zero.
- R11: Whenever out_valid is high, flags is one of exactly four codes: 4'b1000, 4'b0110, 4'b0010 or 4'b0011. Invalid is only ever raised together with the unordered code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opd_d | input | 32 | Left operand, packed single precision |
| opd_m | input | 32 | Right operand, packed single precision |
| sig_mode | input | 1 | 1: any NaN raises invalid |
| zero_mode | input | 1 | 1: right operand replaced by +0 |
| out_valid | output | 1 | Result valid |
| flags | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Every result follows from a single input pair through at most one register. A faulty classification or ordering term therefore shows up as a wrong flag code, or a wrong invalid bit, in the cycle right after the pair is accepted. The risky cases are at the edges of the number line. These are zero against negative zero, same-sign negative pairs where the integer order flips, and NaNs that differ only in fraction bit 22. Long random runs with these classes weighted up expose an inverted or missing term within a few hundred vectors. A fault in the zero-operand substitution shows as flags that still depend on opd_m.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    // condition codes, bit order {N,Z,C,V}
    localparam logic [3:0] CC_LT  = 4'b1000;
    localparam logic [3:0] CC_EQ  = 4'b0110;
    localparam logic [3:0] CC_GT  = 4'b0010;
    localparam logic [3:0] CC_UNO = 4'b0011;

    typedef struct packed {
        logic       vld;
        logic [3:0] cc;
        logic       inv;
    } cmp_res_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] word,
    output logic         is_nan,
    output logic         is_sig,
    output logic         is_zero
);
    logic exp_max;
    logic frac_nz;

    always_comb begin
        exp_max = &word[W-2:MAN_W];
        frac_nz = |word[MAN_W-1:0];
        is_nan  = exp_max && frac_nz;
        // quiet marker is the top fraction bit
        is_sig  = is_nan && !word[MAN_W-1];
        is_zero = ~|word[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output logic         lt,
    output logic         eq
);
    logic sa;
    logic sb;
    logic ult;

    always_comb begin
        sa  = a[W-1];
        sb  = b[W-1];
        ult = a < b;
        eq  = (a == b) || (a_zero && b_zero);
        if (eq)
            lt = 1'b0;
        else if (sa != sb)
            lt = sa;
        else
            lt = sa ? !ult : ult;
    end
endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
    import fcmp_pkg::*;
#(
    parameter int EXPW    = EXP_W,
    parameter int MANW    = MAN_W,
    parameter bit REG_OUT = 1'b1,
    localparam int W = 1 + EXPW + MANW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] opd_d,
    input  logic [W-1:0] opd_m,
    input  logic         sig_mode,
    input  logic         zero_mode,
    output logic         out_valid,
    output logic [3:0]   flags,
    output logic         invalid
);
    localparam int NOPS = 2;

    logic [W-1:0] opnd [NOPS];
    logic [NOPS-1:0] nan_v;
    logic [NOPS-1:0] sig_v;
    logic [NOPS-1:0] zero_v;
    logic lt_w;
    logic eq_w;
    cmp_res_t res_d;
    cmp_res_t res_q;

    always_comb begin
        opnd[0] = opd_d;
        opnd[1] = zero_mode ? '0 : opd_m;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXPW), .MAN_W(MANW)) u_cls (
            .word    (opnd[g]),
            .is_nan  (nan_v[g]),
            .is_sig  (sig_v[g]),
            .is_zero (zero_v[g])
        );
    end

    fcmp_order #(.W(W)) u_ord (
        .a      (opnd[0]),
        .b      (opnd[1]),
        .a_zero (zero_v[0]),
        .b_zero (zero_v[1]),
        .lt     (lt_w),
        .eq     (eq_w)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        if (|nan_v) begin
            res_d.cc  = CC_UNO;
            res_d.inv = sig_mode || (|sig_v);
        end else if (eq_w) begin
            res_d.cc  = CC_EQ;
        end else if (lt_w) begin
            res_d.cc  = CC_LT;
        end else begin
            res_d.cc  = CC_GT;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        // R10: result strobe trails the input strobe by one clock
        assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid && rst_n));

        // R8: zero compare of a zero left operand is always equal
        assert_zero_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && zero_mode && (opd_d[W-2:0] == '0)) |=> (flags == CC_EQ && !invalid));
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign out_valid = res_q.vld;
    assign flags     = res_q.cc;
    assign invalid   = res_q.inv;

    // R11: only four legal codes leave the block
    assert_legal_cc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags == CC_LT || flags == CC_EQ || flags == CC_GT || flags == CC_UNO));

    // R5 / R7: invalid accompanies unordered only
    assert_inv_uno_R7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (flags == CC_UNO));

    // R1: zero flag never appears without carry
    assert_z_with_c_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flags[2] |-> flags[1]);
endmodule

// File: tb/sim_fcmp_nzcv.sv
module sim_fcmp_nzcv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opd_d = '0;
    logic [31:0] opd_m = '0;
    logic        sig_mode = 1'b0;
    logic        zero_mode = 1'b0;
    logic        out_valid;
    logic [3:0]  flags;
    logic        invalid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fcmp_nzcv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opd_d(opd_d), .opd_m(opd_m), .sig_mode(sig_mode), .zero_mode(zero_mode),
        .out_valid(out_valid), .flags(flags), .invalid(invalid)
    );

    function automatic bit ref_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    // monotone key: larger key means larger value, zeros collapse
    function automatic logic [31:0] ref_key(input logic [31:0] w);
        if (w[30:0] == 0) return 32'h8000_0000;
        if (w[31])        return ~w;
        return w | 32'h8000_0000;
    endfunction

    function automatic logic [4:0] ref_res(input logic [31:0] d, input logic [31:0] m0,
                                           input bit sm, input bit zm);
        logic [31:0] m;
        bit inv;
        m = zm ? 32'h0 : m0;
        if (ref_nan(d) || ref_nan(m)) begin
            inv = sm || (ref_nan(d) && !d[22]) || (ref_nan(m) && !m[22]);
            return {4'b0011, inv};
        end
        if (ref_key(d) == ref_key(m)) return {4'b0110, 1'b0};
        if (ref_key(d) <  ref_key(m)) return {4'b1000, 1'b0};
        return {4'b0010, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [31:0] d, input logic [31:0] m,
                       input bit sm, input bit zm);
        logic [4:0] e;
        @(negedge clk);
        opd_d = d; opd_m = m; sig_mode = sm; zero_mode = zm; in_valid = 1'b1;
        e = ref_res(d, m, sm, zm);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R10 valid"}, {31'd0, out_valid}, 32'd1);
        check(req, {27'd0, flags, invalid}, {27'd0, e});
    endtask

    function automatic logic [31:0] pick_word();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 6)
            0: r[30:23] = 8'hFF;
            1: r[30:0]  = '0;
            2: r[30:23] = 8'hFF & {8{r[0]}};
            3: r[22:0]  = '0;
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10 reset", {27'd0, out_valid, flags}, 32'd0);
        check("R10 reset inv", {31'd0, invalid}, 32'd0);
        rst_n = 1'b1;

        run("R1 pz vs nz",       32'h0000_0000, 32'h8000_0000, 0, 0);
        run("R1 same word",      32'h3F80_0000, 32'h3F80_0000, 0, 0);
        run("R2 neg below pos",  32'hBF80_0000, 32'h3F80_0000, 0, 0);
        run("R3 two above one",  32'h4000_0000, 32'h3F80_0000, 0, 0);
        run("R9 neg inverted",   32'hC000_0000, 32'hBF80_0000, 0, 0);
        run("R9 neg vs nzero",   32'h8000_0001, 32'h0000_0000, 0, 0);
        run("R7 inf equal",      32'h7F80_0000, 32'h7F80_0000, 1, 0);
        run("R7 ninf below inf", 32'hFF80_0000, 32'h7F80_0000, 1, 0);
        run("R5 qnan quiet",     32'h7FC0_0000, 32'h3F80_0000, 0, 0);
        run("R5 snan quiet",     32'h3F80_0000, 32'h7F80_0001, 0, 0);
        run("R6 qnan signal",    32'h7FC0_0000, 32'h3F80_0000, 1, 0);
        run("R4 both nan",       32'hFFC0_0001, 32'h7FC0_0000, 0, 0);
        run("R8 zero ignores m nan", 32'h3F80_0000, 32'h7F80_0001, 0, 1);
        run("R8 neg vs zero",    32'hBF80_0000, 32'h4000_0000, 1, 1);
        run("R8 nzero vs zero",  32'h8000_0000, 32'hFFFF_FFFF, 0, 1);

        @(negedge clk);
        check("R10 idle", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = pick_word();
            b = ($urandom % 8 == 0) ? a : pick_word();
            if ($urandom % 8 == 1) b = a ^ 32'h8000_0000;
            run("R9 random", a, b, 1'($urandom), 1'($urandom % 5 == 0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule